// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load-Use Interlock

This block sits in the decode stage of a five-stage in-order integer pipeline. For each of the two source fields of the instruction in decode, it selects the operand that goes into the ID/EX pipeline register. The candidates are a hard zero, the value the EX stage is about to pass on, the value the MEM stage is headed to write back, and a register file read that already includes the write-back of the current cycle. Operand B can instead take the sign-extended short immediate of an ALU-immediate instruction.

The block also raises an interlock when the decode instruction reads the destination of a load that is still in EX. While the interlock is high, the operand register holds its contents. The register file, the ALU and the fetch and branch logic lie outside the block. The register file read addresses are driven from the block, and the read data comes back to it.

Top module: `opnd_bypass`

## Requirements
- R1: A source field of 0 (the hard-wired zero register) gives an operand of 0, even when a destination tag matches it.
- R2: A nonzero source that equals the EX destination takes the EX ALU result when the EX class is not load (2) or store (3). Class codes: jump 0, branch-if-zero 1, load 2, store 3, ALU-immediate 4, ALU-register 5.
- R3: A nonzero source that equals the EX destination, with EX class load (2) or store (3), takes the EX second operand (the store data), not the address.
- R4: Otherwise, a source that equals the MEM destination takes the memory read data when the MEM load flag is 1, and the MEM result when it is 0.
- R5: Otherwise, the operand is the register file data. When the write-back destination equals the source, it is the write-back data instead (write-through).
- R6: When the decode class is ALU-immediate (4), operand B is the 16-bit immediate sign-extended to 32 bits, whatever its source matches.
- R7: The interlock output is 1 exactly when the EX slot is valid, the EX class is load (2), the decode slot is valid, and either source field equals the EX destination.
- R8: The operand registers reset to 0 under the asynchronous active-low reset. They load the selected operands on each clock edge with the interlock low, and hold their value on an edge with the interlock high.
- R9: The register file read addresses equal the decode source fields 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_class | input | 3 | Decode instruction class code |
| id_src1 | input | 5 | Decode source field 1 |
| id_src2 | input | 5 | Decode source field 2 |
| id_imm | input | 16 | Decode short immediate |
| ex_valid | input | 1 | EX slot holds a real instruction |
| ex_class | input | 3 | EX instruction class code |
| ex_dest | input | 5 | EX destination tag (0 for bubbles) |
| ex_alu_res | input | 32 | EX ALU result |
| ex_opnd_b | input | 32 | EX second operand (store data) |
| mem_dest | input | 5 | MEM destination tag |
| mem_is_load | input | 1 | MEM slot holds a load |
| mem_rdata | input | 32 | Data memory read data |
| mem_result | input | 32 | MEM-stage result |
| wb_dest | input | 5 | Write-back destination |
| wb_data | input | 32 | Write-back data |
| rf_raddr_a | output | 5 | Register file read address A |
| rf_raddr_b | output | 5 | Register file read address B |
| rf_rdata_a | input | 32 | Register file read data A |
| rf_rdata_b | input | 32 | Register file read data B |
| issue_stall | output | 1 | Load-use interlock |
| opa_q | output | 32 | Registered operand A |
| opb_q | output | 32 | Registered operand B |

## Verification
The bench goes after sources where the EX, MEM and write-back tags all match at the same time. A priority inversion there would hand decode a stale value that is one or two instructions old. It sets a zero source against a matching zero tag: a design that forwards register 0 would pick up garbage. It also sends a load or store through EX, where a design that takes the address would forward the wrong word. On the interlock, it drives the valid bits off and an immediate instruction whose source 2 matches. A wrong design would either stall when no load hazard exists, or overwrite the held operands during a stall.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int WORD_W = 32;
  localparam int AREG_W = 5;
  localparam int IMM_W  = 16;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_JUMP = 3'd0,
    CLS_BEQZ = 3'd1,
    CLS_LOAD = 3'd2,
    CLS_STOR = 3'd3,
    CLS_ALUI = 3'd4,
    CLS_ALUR = 3'd5
  } instr_cls_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int DATA_W = 32,
  parameter int AREG_W = 5
) (
  input  logic [AREG_W-1:0] src,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [AREG_W-1:0] ex_dest,
  input  logic [DATA_W-1:0] ex_fwd,
  input  logic [AREG_W-1:0] mem_dest,
  input  logic [DATA_W-1:0] mem_fwd,
  input  logic [AREG_W-1:0] wb_dest,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] opnd
);
  localparam logic [AREG_W-1:0] ZREG = '0;

  always_comb begin
    if (imm_sel)                              opnd = imm_val;
    else if (src == ZREG)                     opnd = '0;
    else if (src == ex_dest)                  opnd = ex_fwd;
    else if (src == mem_dest)                 opnd = mem_fwd;
    else if (src == wb_dest)                  opnd = wb_data;
    else                                      opnd = rf_rdata;
  end
endmodule

// File: rtl/ld_use_detect.sv
module ld_use_detect #(
  parameter int AREG_W = 5
) (
  input  logic              ex_valid,
  input  logic              ex_is_load,
  input  logic              id_valid,
  input  logic [AREG_W-1:0] src1,
  input  logic [AREG_W-1:0] src2,
  input  logic [AREG_W-1:0] ex_dest,
  output logic              stall
);
  logic hit;
  always_comb begin
    hit   = (src1 == ex_dest) || (src2 == ex_dest);
    stall = ex_valid && ex_is_load && id_valid && hit;
  end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import bypass_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int AREG_W_P = AREG_W,
  parameter int IMM_W_P = IMM_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 id_valid,
  input  logic [CLS_W-1:0]     id_class,
  input  logic [AREG_W_P-1:0]  id_src1,
  input  logic [AREG_W_P-1:0]  id_src2,
  input  logic [IMM_W_P-1:0]   id_imm,
  input  logic                 ex_valid,
  input  logic [CLS_W-1:0]     ex_class,
  input  logic [AREG_W_P-1:0]  ex_dest,
  input  logic [DATA_W-1:0]    ex_alu_res,
  input  logic [DATA_W-1:0]    ex_opnd_b,
  input  logic [AREG_W_P-1:0]  mem_dest,
  input  logic                 mem_is_load,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic [DATA_W-1:0]    mem_result,
  input  logic [AREG_W_P-1:0]  wb_dest,
  input  logic [DATA_W-1:0]    wb_data,
  output logic [AREG_W_P-1:0]  rf_raddr_a,
  output logic [AREG_W_P-1:0]  rf_raddr_b,
  input  logic [DATA_W-1:0]    rf_rdata_a,
  input  logic [DATA_W-1:0]    rf_rdata_b,
  output logic                 issue_stall,
  output logic [DATA_W-1:0]    opa_q,
  output logic [DATA_W-1:0]    opb_q
);
  localparam int NOPND = 2;
  localparam int EXT_W = DATA_W - IMM_W_P;

  instr_cls_e id_cls, ex_cls;
  logic [DATA_W-1:0] ex_fwd, mem_fwd, imm_sext;
  logic ex_is_mem, ex_is_load;

  logic [AREG_W_P-1:0] src_v   [NOPND];
  logic [DATA_W-1:0]   rf_v    [NOPND];
  logic                imm_v   [NOPND];
  logic [DATA_W-1:0]   sel_v   [NOPND];
  logic [DATA_W-1:0]   opnd_d  [NOPND];
  logic [DATA_W-1:0]   opnd_q  [NOPND];

  always_comb begin
    id_cls     = instr_cls_e'(id_class);
    ex_cls     = instr_cls_e'(ex_class);
    ex_is_load = (ex_cls == CLS_LOAD);
    ex_is_mem  = ex_is_load || (ex_cls == CLS_STOR);
    ex_fwd     = ex_is_mem ? ex_opnd_b : ex_alu_res;
    mem_fwd    = mem_is_load ? mem_rdata : mem_result;
    imm_sext   = {{EXT_W{id_imm[IMM_W_P-1]}}, id_imm};
    src_v[0]   = id_src1;
    src_v[1]   = id_src2;
    rf_v[0]    = rf_rdata_a;
    rf_v[1]    = rf_rdata_b;
    imm_v[0]   = 1'b0;
    imm_v[1]   = (id_cls == CLS_ALUI);
  end

  assign rf_raddr_a = id_src1;
  assign rf_raddr_b = id_src2;

  ld_use_detect #(.AREG_W(AREG_W_P)) u_ldu (
    .ex_valid   (ex_valid),
    .ex_is_load (ex_is_load),
    .id_valid   (id_valid),
    .src1       (id_src1),
    .src2       (id_src2),
    .ex_dest    (ex_dest),
    .stall      (issue_stall)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fwd_select #(.DATA_W(DATA_W), .AREG_W(AREG_W_P)) u_sel (
      .src      (src_v[g]),
      .imm_sel  (imm_v[g]),
      .imm_val  (imm_sext),
      .ex_dest  (ex_dest),
      .ex_fwd   (ex_fwd),
      .mem_dest (mem_dest),
      .mem_fwd  (mem_fwd),
      .wb_dest  (wb_dest),
      .wb_data  (wb_data),
      .rf_rdata (rf_v[g]),
      .opnd     (sel_v[g])
    );

    always_comb begin
      if (!issue_stall) opnd_d[g] = sel_v[g];
      else              opnd_d[g] = opnd_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) opnd_q[g] <= '0;
      else        opnd_q[g] <= opnd_d[g];
    end
  end

  assign opa_q = opnd_q[0];
  assign opb_q = opnd_q[1];
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk
  import bypass_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        id_valid,
  input logic [2:0]  id_class,
  input logic [4:0]  id_src1,
  input logic [4:0]  id_src2,
  input logic [15:0] id_imm,
  input logic        ex_valid,
  input logic [2:0]  ex_class,
  input logic [4:0]  ex_dest,
  input logic [31:0] ex_alu_res,
  input logic [31:0] ex_opnd_b,
  input logic [4:0]  rf_raddr_a,
  input logic [4:0]  rf_raddr_b,
  input logic        issue_stall,
  input logic [31:0] opa_q,
  input logic [31:0] opb_q
);
  // R1
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src1 == 5'd0 && !issue_stall) |=> (opa_q == 32'd0));

  // R2
  ex_alu_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src1 != 5'd0 && id_src1 == ex_dest && ex_class != 3'd2 &&
     ex_class != 3'd3 && !issue_stall) |=> (opa_q == $past(ex_alu_res)));

  // R3
  ex_mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src1 != 5'd0 && id_src1 == ex_dest &&
     (ex_class == 3'd2 || ex_class == 3'd3) && !issue_stall)
    |=> (opa_q == $past(ex_opnd_b)));

  // R6
  imm_opb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_class == 3'd4 && !issue_stall)
    |=> (opb_q == {{16{$past(id_imm[15])}}, $past(id_imm)}));

  // R7
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |-> (ex_valid && id_valid && ex_class == 3'd2));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |=> ($stable(opa_q) && $stable(opb_q)));

  // R9
  raddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_raddr_a == id_src1 && rf_raddr_b == id_src2));
endmodule

bind opnd_bypass opnd_bypass_chk u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
  .id_src1(id_src1), .id_src2(id_src2), .id_imm(id_imm),
  .ex_valid(ex_valid), .ex_class(ex_class), .ex_dest(ex_dest),
  .ex_alu_res(ex_alu_res), .ex_opnd_b(ex_opnd_b),
  .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
  .issue_stall(issue_stall), .opa_q(opa_q), .opb_q(opb_q)
);

// File: tb/opnd_bypass_tb_top.sv
`timescale 1ns/1ps
module opnd_bypass_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic id_valid, ex_valid, mem_is_load;
  logic [2:0] id_class, ex_class;
  logic [4:0] id_src1, id_src2, ex_dest, mem_dest, wb_dest;
  logic [15:0] id_imm;
  logic [31:0] ex_alu_res, ex_opnd_b, mem_rdata, mem_result, wb_data;
  logic [4:0] rf_raddr_a, rf_raddr_b;
  logic [31:0] rf_rdata_a, rf_rdata_b, opa_q, opb_q;
  logic issue_stall;

  logic [31:0] rf_m [32];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] prev_a = 0, prev_b = 0;

  always #5 clk = ~clk;

  opnd_bypass dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
    .id_src1(id_src1), .id_src2(id_src2), .id_imm(id_imm),
    .ex_valid(ex_valid), .ex_class(ex_class), .ex_dest(ex_dest),
    .ex_alu_res(ex_alu_res), .ex_opnd_b(ex_opnd_b), .mem_dest(mem_dest),
    .mem_is_load(mem_is_load), .mem_rdata(mem_rdata), .mem_result(mem_result),
    .wb_dest(wb_dest), .wb_data(wb_data), .rf_raddr_a(rf_raddr_a),
    .rf_raddr_b(rf_raddr_b), .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .issue_stall(issue_stall), .opa_q(opa_q), .opb_q(opb_q)
  );

  // reference register file: sequential, written by write-back
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf_m[i] <= 32'h1000_0000 + i * 32'h0001_0101;
    end else if (wb_dest != 5'd0) begin
      rf_m[wb_dest] <= wb_data;
    end
  end
  assign rf_rdata_a = rf_m[rf_raddr_a];
  assign rf_rdata_b = rf_m[rf_raddr_b];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_src(input logic [4:0] s, output string tag);
    if (s == 0) begin tag = "R1"; return 0; end
    if (s == ex_dest) begin
      if (ex_class == 3'd2 || ex_class == 3'd3) begin tag = "R3"; return ex_opnd_b; end
      tag = "R2"; return ex_alu_res;
    end
    if (s == mem_dest) begin tag = "R4"; return mem_is_load ? mem_rdata : mem_result; end
    tag = "R5";
    if (s == wb_dest) return wb_data;
    return rf_m[s];
  endfunction

  task automatic idle();
    id_valid = 1; id_class = 3'd5; id_src1 = 5'd20; id_src2 = 5'd21; id_imm = 16'h0;
    ex_valid = 0; ex_class = 3'd5; ex_dest = 0; ex_alu_res = 32'hE0E0_0001;
    ex_opnd_b = 32'hE0E0_0002; mem_dest = 0; mem_is_load = 0;
    mem_rdata = 32'hDDDD_0001; mem_result = 32'hDDDD_0002; wb_dest = 0; wb_data = 32'hBBBB_0001;
  endtask

  // inputs already driven after a negedge
  task automatic step();
    logic exp_st;
    logic [31:0] ea, eb;
    string ta, tb;
    #1;
    exp_st = ex_valid && ex_class == 3'd2 && id_valid &&
             (id_src1 == ex_dest || id_src2 == ex_dest);
    chk("R7 stall", {31'd0, issue_stall}, {31'd0, exp_st});
    chk("R9 raddr", {22'd0, rf_raddr_a, rf_raddr_b}, {22'd0, id_src1, id_src2});
    if (exp_st) begin
      ea = prev_a; eb = prev_b; ta = "R8 hold"; tb = "R8 hold";
    end else begin
      ea = ref_src(id_src1, ta);
      if (id_class == 3'd4) begin eb = {{16{id_imm[15]}}, id_imm}; tb = "R6"; end
      else eb = ref_src(id_src2, tb);
    end
    @(posedge clk);
    @(negedge clk);
    chk({ta, " opa"}, opa_q, ea);
    chk({tb, " opb"}, opb_q, eb);
    prev_a = ea; prev_b = eb;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset opa", opa_q, 32'd0);
    chk("R8 reset opb", opb_q, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: zero source against matching zero tags
    idle(); id_src1 = 0; ex_dest = 0; mem_dest = 0; wb_dest = 0; step();
    // R2: EX priority over MEM and WB
    idle(); id_src1 = 3; ex_dest = 3; mem_dest = 3; wb_dest = 3; ex_alu_res = 32'hAAAA_0003; step();
    // R3: load in EX (slot invalid to avoid interlock) forwards store-data operand
    idle(); id_src2 = 6; ex_dest = 6; ex_class = 3'd2; ex_opnd_b = 32'hB0B0_0006; step();
    idle(); id_src1 = 6; ex_dest = 6; ex_class = 3'd3; ex_valid = 1; step();
    // R4: MEM load data and MEM result
    idle(); id_src2 = 5; mem_dest = 5; wb_dest = 5; mem_is_load = 1; step();
    idle(); id_src1 = 5; mem_dest = 5; mem_is_load = 0; step();
    // R5: write-through and plain read
    idle(); id_src1 = 7; wb_dest = 7; wb_data = 32'h7777_7777; step();
    idle(); id_src1 = 7; id_src2 = 9; step();
    // R6: immediate overrides a matching source
    idle(); id_class = 3'd4; id_src2 = 4; ex_dest = 4; id_imm = 16'h8001; step();
    idle(); id_class = 3'd4; id_imm = 16'h7FFE; step();
    // R7/R8: load-use stall holds operands, then releases
    idle(); ex_valid = 1; ex_class = 3'd2; ex_dest = 8; id_src2 = 8; step();
    idle(); ex_valid = 1; ex_class = 3'd2; ex_dest = 8; id_src1 = 8; id_valid = 0; step();
    idle(); ex_valid = 0; ex_class = 3'd2; ex_dest = 8; id_src1 = 8; step();

    // random mix over a small register range
    for (int n = 0; n < 600; n++) begin
      id_valid = $urandom_range(0, 3) != 0;
      id_class = 3'($urandom_range(0, 5));
      id_src1 = 5'($urandom_range(0, 3));
      id_src2 = 5'($urandom_range(0, 3));
      id_imm = 16'($urandom);
      ex_valid = $urandom_range(0, 1) == 1;
      ex_class = 3'($urandom_range(0, 5));
      ex_dest = 5'($urandom_range(0, 3));
      ex_alu_res = $urandom; ex_opnd_b = $urandom;
      mem_dest = 5'($urandom_range(0, 3));
      mem_is_load = $urandom_range(0, 1) == 1;
      mem_rdata = $urandom; mem_result = $urandom;
      wb_dest = 5'($urandom_range(0, 3));
      wb_data = $urandom;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule